// File: doc/BRIEF.md
# Strap-Gated 64-bit Memory Window Decoder

This block holds the base address of a 1 MB prefetchable memory window for a two-port memory bridge. It also decides, for each request, whether the window applies. The 64-bit base is split across two 32-bit configuration registers. The lower register carries base bits 31:20 and the upper register carries bits 63:32. Software programs them through a small configuration port that has an offset, write data, byte enables and combinational read data.

A strap input turns the whole feature on or off. The block captures the strap on the first clock edge after reset is released and holds that value until the next reset. While the window is disabled, both registers read as zero and writes to them are dropped. While it is enabled, the decode works in one direction only. A primary-side request whose address falls inside the window is claimed, so it is forwarded toward the secondary side. A secondary-side request that falls inside the window is marked as ignored. This window never claims anything on the secondary side.

Top module: `win_decode`

## Requirements
- R1: After reset, the upper register (offset 0x14) and the lower register (offset 0x10) both read 0x0000_0000.
- R2: With the window enabled, all 32 bits of the upper register at offset 0x14 are read/write and hold base address bits 63:32.
- R3: With the window enabled, bits 31:20 of the lower register at offset 0x10 are read/write and hold base bits 31:20. Its bits 19:0 always read zero and ignore writes.
- R4: A configuration write updates only the bytes whose byte-enable bit is set: enable bit i selects write-data bits 8i+7:8i.
- R5: With the window disabled, both registers read zero, writes to them have no effect, and no request is ever claimed or ignored.
- R6: `pri_claim_o` is high when `pri_valid_i` is high, the window is enabled, and `pri_addr_i[63:20]` equals base bits 63:20.
- R7: `pri_claim_o` is low for an address one byte below the base, for an address at the base plus 1 MB, when the upper 32 bits differ, and whenever `pri_valid_i` is low.
- R8: `sec_ignore_o` is high for a valid secondary request whose bits 63:20 match the base. It is low for a miss or an invalid request, and a secondary request never raises `pri_claim_o`.
- R9: The strap is captured on the first clock edge after reset release. Later changes of the strap leave the register contents and the decode unchanged until the next reset.
- R10: `pri_claim_o` and `sec_ignore_o` are combinational: they follow a change on the address and valid inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_en_i | input | 1 | Window enable strap |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration byte offset |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_be_i | input | 4 | Write byte enables |
| cfg_rdata_o | output | 32 | Read data for `cfg_addr_i` |
| pri_valid_i | input | 1 | Primary request valid |
| pri_addr_i | input | 64 | Primary request address |
| pri_claim_o | output | 1 | Primary request claimed for forwarding |
| sec_valid_i | input | 1 | Secondary request valid |
| sec_addr_i | input | 64 | Secondary request address |
| sec_ignore_o | output | 1 | Secondary request hits window and is ignored |

## Verification
The bench builds the block with its defaults: a 20-bit window offset (1 MB), a 64-bit address, and the registers at 0x10 and 0x14. These values bring within reach the exact 1 MB edges around a base whose upper half is nonzero. They also cover the zero field below bit 20 in the lower register and the byte-lane masking of both registers. A separate reset with the strap low reaches the disabled state. The bench also flips the strap after capture, which shows that the captured value stays in force.

// File: rtl/win_decode.sv
module win_decode #(
  parameter int ADDR_W    = 64,
  parameter int WIN_BITS  = 20,
  parameter int CFG_AW    = 8,
  parameter logic [7:0] LO_OFS = 8'h10,
  parameter logic [7:0] UP_OFS = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_en_i,
  input  logic              cfg_wr_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic [3:0]        cfg_be_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              pri_valid_i,
  input  logic [ADDR_W-1:0] pri_addr_i,
  output logic              pri_claim_o,
  input  logic              sec_valid_i,
  input  logic [ADDR_W-1:0] sec_addr_i,
  output logic              sec_ignore_o
);
  localparam int LO_W = 32 - WIN_BITS;
  localparam int HI_W = ADDR_W - 32;
  localparam int CMP_W = ADDR_W - WIN_BITS;

  logic              captured, strap_q;
  logic [HI_W-1:0]   up_q;
  logic [LO_W-1:0]   lo_q;
  logic [31:0]       be_mask, lo_full, lo_next, up_next;
  logic [CMP_W-1:0]  base_cmp;
  logic              wr_up, wr_lo;

  for (genvar i = 0; i < 4; i++) begin : g_mask
    assign be_mask[8*i +: 8] = {8{cfg_be_i[i]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      captured <= 1'b0;
      strap_q  <= 1'b0;
    end else if (!captured) begin
      captured <= 1'b1;
      strap_q  <= strap_en_i;
    end
  end

  assign wr_up   = cfg_wr_i && strap_q && (cfg_addr_i == UP_OFS);
  assign wr_lo   = cfg_wr_i && strap_q && (cfg_addr_i == LO_OFS);
  assign lo_full = {lo_q, {WIN_BITS{1'b0}}};
  assign lo_next = (lo_full & ~be_mask) | (cfg_wdata_i & be_mask);
  assign up_next = (up_q & ~be_mask) | (cfg_wdata_i & be_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= '0;
      lo_q <= '0;
    end else begin
      if (wr_up) up_q <= up_next;
      if (wr_lo) lo_q <= lo_next[31:WIN_BITS];
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    if (strap_q) begin
      if (cfg_addr_i == UP_OFS) cfg_rdata_o = up_q;
      else if (cfg_addr_i == LO_OFS) cfg_rdata_o = lo_full;
    end
  end

  assign base_cmp     = {up_q, lo_q};
  assign pri_claim_o  = strap_q && pri_valid_i && (pri_addr_i[ADDR_W-1:WIN_BITS] == base_cmp);
  assign sec_ignore_o = strap_q && sec_valid_i && (sec_addr_i[ADDR_W-1:WIN_BITS] == base_cmp);

  a_r5_off_no_claim: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_q |-> (!pri_claim_o && !sec_ignore_o));
  a_r5_off_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!strap_q && cfg_addr_i == UP_OFS) |-> (cfg_rdata_o == 32'h0));
  a_r3_low_field_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr_i == LO_OFS) |-> (cfg_rdata_o[WIN_BITS-1:0] == '0));
  a_r7_claim_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pri_claim_o |-> pri_valid_i);
  a_r8_ignore_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    sec_ignore_o |-> sec_valid_i);
  a_r2_full_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_i && strap_q && cfg_addr_i == UP_OFS && cfg_be_i == 4'hF) |=> (up_q == $past(cfg_wdata_i)));
  a_r9_strap_held: assert property (@(posedge clk) disable iff (!rst_n)
    (captured && $past(captured)) |-> $stable(strap_q));
endmodule

// File: tb/win_decode_tb_top.sv
module win_decode_tb_top;
  logic clk = 0, rst_n = 0, strap = 0;
  logic cfg_wr = 0;
  logic [7:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic [3:0] cfg_be = 0;
  logic pri_valid = 0, sec_valid = 0, pri_claim, sec_ignore;
  logic [63:0] pri_addr = 0, sec_addr = 0;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  win_decode dut_i (
    .clk(clk), .rst_n(rst_n), .strap_en_i(strap),
    .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_be_i(cfg_be), .cfg_rdata_o(cfg_rdata),
    .pri_valid_i(pri_valid), .pri_addr_i(pri_addr), .pri_claim_o(pri_claim),
    .sec_valid_i(sec_valid), .sec_addr_i(sec_addr), .sec_ignore_o(sec_ignore)
  );

  localparam logic [63:0] BASE = 64'h0000_0012_3450_0000;
  // {is_sec, valid, addr, expected}
  localparam int NV = 9;
  localparam logic [66:0] VEC [NV] = '{
    {1'b0, 1'b1, BASE,                    1'b1},
    {1'b0, 1'b1, BASE + 64'hF_FFFF,       1'b1},
    {1'b0, 1'b1, BASE + 64'h10_0000,      1'b0},
    {1'b0, 1'b1, BASE - 64'h1,            1'b0},
    {1'b0, 1'b0, BASE,                    1'b0},
    {1'b0, 1'b1, BASE ^ 64'h1_0000_0000,  1'b0},
    {1'b1, 1'b1, BASE + 64'h8_0000,       1'b1},
    {1'b1, 1'b1, BASE + 64'h10_0000,      1'b0},
    {1'b1, 1'b0, BASE,                    1'b0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk); rst_n = 0; strap = s;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
    @(negedge clk); cfg_wr = 0; cfg_be = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); cfg_addr = a; #1;
    chk(tag, {32'h0, cfg_rdata}, {32'h0, exp});
  endtask

  task automatic pri_chk(input string tag, input logic v, input logic [63:0] a, input logic exp);
    @(negedge clk); pri_valid = v; pri_addr = a; #1;
    chk(tag, {63'h0, pri_claim}, {63'h0, exp});
    pri_valid = 0;
  endtask

  initial begin
    #2ms;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    // R5: strap low at reset
    do_reset(1'b0);
    wr(8'h14, 32'hFFFF_FFFF, 4'hF);
    wr(8'h10, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R5 upper reads zero", 8'h14, 32'h0);
    rd_chk("R5 lower reads zero", 8'h10, 32'h0);
    pri_chk("R5 no claim", 1'b1, 64'h0, 1'b0);
    @(negedge clk); sec_valid = 1; sec_addr = 64'h0; #1;
    chk("R5 no ignore", {63'h0, sec_ignore}, 64'h0);
    sec_valid = 0;

    // R1: strap high, reset values
    do_reset(1'b1);
    rd_chk("R1 upper reset", 8'h14, 32'h0);
    rd_chk("R1 lower reset", 8'h10, 32'h0);
    pri_chk("R6 hit at zero base", 1'b1, 64'h0000_0000_000A_BCDE, 1'b1);

    // R4, R2, R3
    wr(8'h14, 32'hFFFF_FFFF, 4'b0101);
    rd_chk("R4 upper byte lanes", 8'h14, 32'h00FF_00FF);
    wr(8'h14, 32'hA5A5_5A5A, 4'hF);
    rd_chk("R2 upper full write", 8'h14, 32'hA5A5_5A5A);
    wr(8'h10, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R3 lower field only", 8'h10, 32'hFFF0_0000);
    wr(8'h10, 32'h0000_0000, 4'b0100);
    rd_chk("R4 lower byte2 only", 8'h10, 32'hFF00_0000);
    wr(8'h14, BASE[63:32], 4'hF);
    wr(8'h10, BASE[31:0], 4'hF);
    rd_chk("R2 upper base", 8'h14, BASE[63:32]);
    rd_chk("R3 lower base", 8'h10, BASE[31:0]);

    // R6 R7 R8 R10: table walk, sampled 1 ns after the inputs change
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (VEC[i][66]) begin
        sec_valid = VEC[i][65]; sec_addr = VEC[i][64:1]; #1;
        chk($sformatf("R8 R10 sec vec %0d", i), {63'h0, sec_ignore}, {63'h0, VEC[i][0]});
        chk($sformatf("R8 sec no claim %0d", i), {63'h0, pri_claim}, 64'h0);
      end else begin
        pri_valid = VEC[i][65]; pri_addr = VEC[i][64:1]; #1;
        chk($sformatf("R6 R7 R10 pri vec %0d", i), {63'h0, pri_claim}, {63'h0, VEC[i][0]});
      end
      pri_valid = 0; sec_valid = 0;
    end

    // R9: strap change after capture has no effect
    @(negedge clk); strap = 0;
    repeat (3) @(negedge clk);
    rd_chk("R9 upper held", 8'h14, BASE[63:32]);
    pri_chk("R9 claim held", 1'b1, BASE + 64'h100, 1'b1);
    wr(8'h14, 32'h0000_0077, 4'hF);
    rd_chk("R9 writes still accepted", 8'h14, 32'h0000_0077);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule